// File: doc/BRIEF.md
# Operand Collector Unit Allocation Router

This block sits between the issue stage and a pool of operand collector units. Each execution pipe (simple ALU, special-function, memory) has one issue register, presented here as a valid flag and an instruction tag. The collector units are split into four sets: one for each pipe and one shared general set. Each cycle, a chain of allocation ports hands pending issue registers to free units. A port consumes the issue register it serves, and it binds the claimed unit to the pipe that the instruction came from.

There are two kinds of port. A dedicated port watches one pipe. It looks for a free unit in that pipe's own set first and falls back to the general set. A general port watches all three pipes in the fixed order ALU, SFU, MEM. It considers only the first pipe that is still pending, and it draws only from the general set. The ports are evaluated in a fixed sequence: dedicated ports in pipe order, then the general ports. A later port sees the inputs and units that earlier ports claimed in the same cycle as already gone.

Release pulses from the dispatch side are applied before allocation. A unit released in a cycle can therefore be claimed again in that same cycle. Set sizes, the presence of each dedicated port, the number of general ports and the tag width are parameters. A set of size zero is legal and is never matched.

Top module: `opnd_alloc_router`

## Requirements
- R1: After reset every unit is free, its recorded pipe and tag are zero, and no take or claim is raised while inputs are idle.
- R2: A dedicated port with a pending input claims the lowest-indexed free unit of its own pipe's set. With the default sizes, the ALU set is units 0..1, the SFU set is unit 2 and the general set is units 3..4.
- R3: When its own set has no free unit, a dedicated port claims the lowest-indexed free unit of the general set.
- R4: A general port scans pipes in the order ALU (0), SFU (1), MEM (2). It serves only the first one still pending, and it claims at most one general-set unit per cycle.
- R5: Ports are evaluated in sequence: dedicated ALU, dedicated SFU, dedicated MEM, then the general ports. A later port never claims an input or a unit that an earlier port claimed in the same cycle.
- R6: A claimed unit reads as busy from the next cycle. Its `unit_dest` field holds the source pipe code (0 ALU, 1 SFU, 2 MEM) and its `unit_tag` field holds the tag of that input.
- R7: An input is consumed (`in_take`) in the same cycle that a unit is claimed for it. Each cycle the number of takes equals the number of claims, and a take is raised only for a valid input.
- R8: A release of a busy unit frees it in the same cycle, so that unit can be claimed that cycle. A release of an already free unit has no effect.
- R9: A pending input for which no unit is free is left untaken, and with no input pending no unit is claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 3 | Issue register non-empty, bit p for pipe p |
| in_tag | input | 3*TAG_W | Instruction tag per pipe, pipe p at bits p*TAG_W |
| unit_rel | input | NU | Dispatch release pulse per unit |
| in_take | output | 3 | Issue register consumed this cycle |
| unit_claim | output | NU | Unit claimed this cycle |
| unit_busy | output | NU | Unit holds an instruction |
| unit_dest | output | 2*NU | Bound pipe code per unit, unit u at bits 2*u |
| unit_tag | output | TAG_W*NU | Recorded tag per unit, unit u at bits u*TAG_W |

## Verification
A directed sequence first fills the ALU set and then forces the fallback into the general set. Presenting SFU and MEM together shows that the general port serves MEM only after the SFU input has been consumed. Saturating the whole pool separates "no free unit" from "no request". Timed releases show same-cycle reuse and that a release of a free unit is ignored. A long random phase then presents every mix of valid inputs and releases against a behavioural reference, which tells apart wrong search order, wrong port order and wrong pipe binding.

// File: rtl/opnd_route_pkg.sv
package opnd_route_pkg;

  localparam int NPIPE     = 3;
  localparam int MAX_UNITS = 32;

  typedef logic [1:0] pipe_t;

  localparam pipe_t PIPE_ALU = 2'd0;
  localparam pipe_t PIPE_SFU = 2'd1;
  localparam pipe_t PIPE_MEM = 2'd2;

  // Lowest set bit of avail inside [lo, lo+cnt); -1 when none (cnt 0 never hits)
  function automatic int pick_lowest(input logic [MAX_UNITS-1:0] avail,
                                     input int lo, input int cnt);
    int r;
    r = -1;
    for (int i = MAX_UNITS - 1; i >= 0; i--) begin
      if (i >= lo && i < lo + cnt && avail[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/opnd_route_unit.sv
module opnd_route_unit
  import opnd_route_pkg::*;
#(
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic             rel,
  input  pipe_t            dest_in,
  input  logic [TAG_W-1:0] tag_in,
  output logic             busy,
  output pipe_t            dest,
  output logic [TAG_W-1:0] tag
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      dest <= PIPE_ALU;
      tag  <= '0;
    end else if (alloc) begin
      busy <= 1'b1;
      dest <= dest_in;
      tag  <= tag_in;
    end else if (rel) begin
      busy <= 1'b0;
    end
  end

  AST_ALLOC_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> (!busy || rel)); // R8
  AST_BUSY_AFTER_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> busy); // R6
  AST_REL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rel && busy && !alloc) |=> !busy); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc && !rel) |=> $stable(busy) && $stable(tag)); // R8

endmodule

// File: rtl/opnd_route_port.sv
module opnd_route_port
  import opnd_route_pkg::*;
#(
  parameter int               NU      = 5,
  parameter logic [NPIPE-1:0] IN_MASK = 3'b001,
  parameter int               PRI_LO  = 0,
  parameter int               PRI_N   = 1,
  parameter int               SEC_LO  = 0,
  parameter int               SEC_N   = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPIPE-1:0] pend,
  input  logic [NU-1:0]    avail,
  output logic [NU-1:0]    claim,
  output logic [NPIPE-1:0] took,
  output pipe_t            sel_pipe
);

  logic [MAX_UNITS-1:0] avail_w;
  logic                 port_hit;  // an input is being considered this cycle
  int                   pick_idx;

  assign avail_w = MAX_UNITS'(avail);

  always_comb begin
    port_hit = 1'b0;
    sel_pipe = PIPE_ALU;
    pick_idx = -1;
    claim    = '0;
    took     = '0;
    // only the first pending input of this port is ever considered
    for (int p = 0; p < NPIPE; p++) begin
      if (!port_hit && IN_MASK[p] && pend[p]) begin
        port_hit = 1'b1;
        sel_pipe = pipe_t'(p);
      end
    end
    if (port_hit) begin
      pick_idx = pick_lowest(avail_w, PRI_LO, PRI_N);
      if (pick_idx < 0) pick_idx = pick_lowest(avail_w, SEC_LO, SEC_N);
    end
    for (int u = 0; u < NU; u++) begin
      if (pick_idx == u) claim[u] = 1'b1;
    end
    if (pick_idx >= 0) took[sel_pipe] = 1'b1;
  end

  AST_PORT_ONE_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim)); // R7
  AST_PORT_ONE_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(took)); // R4
  AST_PORT_FREE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (claim & ~avail) == '0); // R5
  AST_PORT_PENDING_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (took & ~(pend & IN_MASK)) == '0); // R5

endmodule

// File: rtl/opnd_alloc_router.sv
module opnd_alloc_router
  import opnd_route_pkg::*;
#(
  parameter int               TAG_W    = 6,
  parameter int               N_ALU    = 2,
  parameter int               N_SFU    = 1,
  parameter int               N_MEM    = 0,
  parameter int               N_GEN    = 2,
  parameter logic [NPIPE-1:0] DED_MASK = 3'b011,
  parameter int               G_PORTS  = 1,
  localparam int              NU       = N_ALU + N_SFU + N_MEM + N_GEN
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPIPE-1:0]       in_valid,
  input  logic [NPIPE*TAG_W-1:0] in_tag,
  input  logic [NU-1:0]          unit_rel,
  output logic [NPIPE-1:0]       in_take,
  output logic [NU-1:0]          unit_claim,
  output logic [NU-1:0]          unit_busy,
  output logic [2*NU-1:0]        unit_dest,
  output logic [TAG_W*NU-1:0]    unit_tag
);

  localparam int LO_ALU = 0;
  localparam int LO_SFU = N_ALU;
  localparam int LO_MEM = N_ALU + N_SFU;
  localparam int LO_GEN = N_ALU + N_SFU + N_MEM;
  localparam int NSTG   = NPIPE + G_PORTS;

  // allocation chain: stage k sees what stages before it left over
  logic [NPIPE-1:0] pend_c  [NSTG+1];
  logic [NU-1:0]    free_c  [NSTG+1];
  logic [NU-1:0]    claim_s [NSTG];
  logic [NPIPE-1:0] took_s  [NSTG];
  pipe_t            sel_s   [NSTG];
  pipe_t            unit_sel [NU];

  assign pend_c[0] = in_valid;
  assign free_c[0] = ~unit_busy | unit_rel;  // releases take effect first

  for (genvar k = 0; k < NPIPE; k++) begin : g_ded
    localparam int OWN_LO = (k == 0) ? LO_ALU : (k == 1) ? LO_SFU : LO_MEM;
    localparam int OWN_N  = (k == 0) ? N_ALU  : (k == 1) ? N_SFU  : N_MEM;
    if (DED_MASK[k]) begin : g_on
      opnd_route_port #(
        .NU(NU), .IN_MASK(NPIPE'(1) << k),
        .PRI_LO(OWN_LO), .PRI_N(OWN_N), .SEC_LO(LO_GEN), .SEC_N(N_GEN)
      ) i_port (
        .clk(clk), .rst_n(rst_n), .pend(pend_c[k]), .avail(free_c[k]),
        .claim(claim_s[k]), .took(took_s[k]), .sel_pipe(sel_s[k])
      );
    end else begin : g_off
      assign claim_s[k] = '0;
      assign took_s[k]  = '0;
      assign sel_s[k]   = PIPE_ALU;
    end
  end

  for (genvar g = 0; g < G_PORTS; g++) begin : g_gen
    opnd_route_port #(
      .NU(NU), .IN_MASK({NPIPE{1'b1}}),
      .PRI_LO(LO_GEN), .PRI_N(N_GEN), .SEC_LO(0), .SEC_N(0)
    ) i_port (
      .clk(clk), .rst_n(rst_n), .pend(pend_c[NPIPE+g]), .avail(free_c[NPIPE+g]),
      .claim(claim_s[NPIPE+g]), .took(took_s[NPIPE+g]), .sel_pipe(sel_s[NPIPE+g])
    );
  end

  for (genvar k = 0; k < NSTG; k++) begin : g_chain
    assign pend_c[k+1] = pend_c[k] & ~took_s[k];
    assign free_c[k+1] = free_c[k] & ~claim_s[k];
  end

  always_comb begin
    unit_claim = '0;
    in_take    = '0;
    for (int u = 0; u < NU; u++) unit_sel[u] = PIPE_ALU;
    for (int k = 0; k < NSTG; k++) begin
      in_take = in_take | took_s[k];
      for (int u = 0; u < NU; u++) begin
        if (claim_s[k][u]) begin
          unit_claim[u] = 1'b1;
          unit_sel[u]   = sel_s[k];
        end
      end
    end
  end

  for (genvar u = 0; u < NU; u++) begin : g_unit
    pipe_t dest_w;
    opnd_route_unit #(.TAG_W(TAG_W)) i_unit (
      .clk(clk), .rst_n(rst_n),
      .alloc(unit_claim[u]), .rel(unit_rel[u]),
      .dest_in(unit_sel[u]),
      .tag_in(in_tag[32'(unit_sel[u])*TAG_W +: TAG_W]),
      .busy(unit_busy[u]), .dest(dest_w), .tag(unit_tag[u*TAG_W +: TAG_W])
    );
    assign unit_dest[2*u +: 2] = dest_w;
  end

  AST_TAKE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (in_take & ~in_valid) == '0); // R7
  AST_TAKE_EQ_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(in_take) == $countones(unit_claim)); // R7
  AST_NO_REQ_NO_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid == '0) |-> (unit_claim == '0)); // R9
  AST_CLAIM_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_claim & unit_busy & ~unit_rel) == '0); // R8

endmodule

// File: tb/test_opnd_alloc_router.sv
`timescale 1ns/1ps
module test_opnd_alloc_router;

  localparam int TW = 6;
  localparam int NU = 5;
  // set ranges for default parameters: ALU 0..1, SFU 2, MEM none, GEN 3..4
  localparam int A_LO = 0, A_N = 2, S_LO = 2, S_N = 1, G_LO = 3, G_N = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [2:0]      in_valid = '0;
  logic [3*TW-1:0] in_tag = '0;
  logic [NU-1:0]   unit_rel = '0;
  logic [2:0]      in_take;
  logic [NU-1:0]   unit_claim, unit_busy;
  logic [2*NU-1:0] unit_dest;
  logic [TW*NU-1:0] unit_tag;

  always #2.5 clk = ~clk;

  opnd_alloc_router i_opnd_alloc_router (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
    .unit_rel(unit_rel), .in_take(in_take), .unit_claim(unit_claim),
    .unit_busy(unit_busy), .unit_dest(unit_dest), .unit_tag(unit_tag)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  int m_busy [NU];
  int m_dest [NU];
  int m_tag  [NU];
  logic [2:0]    e_take;
  logic [NU-1:0] e_claim;
  int e_pipe [NU];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int find_free(input logic [NU-1:0] f, input int lo, input int n);
    for (int i = lo; i < lo + n; i++) if (f[i]) return i;
    return -1;
  endfunction

  task automatic model_eval();
    logic [2:0] pend;
    logic [NU-1:0] f;
    int u;
    bit served;
    pend = in_valid;
    e_take = '0;
    e_claim = '0;
    for (int i = 0; i < NU; i++) f[i] = (m_busy[i] == 0) || unit_rel[i];
    for (int p = 0; p < 2; p++) begin
      if (pend[p]) begin
        u = find_free(f, (p == 0) ? A_LO : S_LO, (p == 0) ? A_N : S_N);
        if (u < 0) u = find_free(f, G_LO, G_N);
        if (u >= 0) begin
          f[u] = 1'b0; e_claim[u] = 1'b1; e_pipe[u] = p;
          pend[p] = 1'b0; e_take[p] = 1'b1;
        end
      end
    end
    served = 0;
    for (int p = 0; p < 3; p++) begin
      if (!served && pend[p]) begin
        served = 1;
        u = find_free(f, G_LO, G_N);
        if (u >= 0) begin
          f[u] = 1'b0; e_claim[u] = 1'b1; e_pipe[u] = p;
          pend[p] = 1'b0; e_take[p] = 1'b1;
        end
      end
    end
  endtask

  task automatic compare_and_advance();
    logic [NU-1:0] eb;
    logic [2*NU-1:0] ed;
    logic [TW*NU-1:0] et;
    for (int i = 0; i < NU; i++) begin
      eb[i] = (m_busy[i] != 0);
      ed[2*i +: 2] = m_dest[i][1:0];
      et[i*TW +: TW] = m_tag[i][TW-1:0];
    end
    model_eval();
    chk("R7 take", 32'(in_take), 32'(e_take));
    chk("R2 claim", 32'(unit_claim), 32'(e_claim));
    chk("R6 busy", 32'(unit_busy), 32'(eb));
    chk("R6 dest", 32'(unit_dest), 32'(ed));
    chk("R6 tag", 32'(unit_tag), 32'(et));
    for (int i = 0; i < NU; i++) begin
      if (e_claim[i]) begin
        m_busy[i] = 1;
        m_dest[i] = e_pipe[i];
        m_tag[i]  = int'(in_tag[e_pipe[i]*TW +: TW]);
      end else if (unit_rel[i]) begin
        m_busy[i] = 0;
      end
    end
  endtask

  task automatic cyc(input logic [2:0] v, input logic [3*TW-1:0] t, input logic [NU-1:0] r);
    @(posedge clk);
    #1;
    in_valid = v; in_tag = t; unit_rel = r;
    @(negedge clk);
    compare_and_advance();
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NU; i++) begin m_busy[i] = 0; m_dest[i] = 0; m_tag[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", 32'(unit_busy), 0);
    chk("R1 claim", 32'(unit_claim), 0);
    chk("R1 take", 32'(in_take), 0);
    chk("R1 tag", 32'(unit_tag), 0);

    cyc(3'b001, {6'd0, 6'd0, 6'd5}, '0);
    chk("R2 first ALU unit", 32'(unit_claim), 32'b00001);
    cyc(3'b001, {6'd0, 6'd0, 6'd6}, '0);
    chk("R2 next ALU unit", 32'(unit_claim), 32'b00010);
    chk("R6 dest/tag unit0", {unit_dest[1:0], unit_tag[5:0]}, {2'd0, 6'd5});
    cyc(3'b001, {6'd0, 6'd0, 6'd7}, '0);
    chk("R3 general fallback", 32'(unit_claim), 32'b01000);
    cyc(3'b110, {6'd12, 6'd11, 6'd0}, '0);
    chk("R5 SFU then general", 32'(unit_claim), 32'b10100);
    chk("R4 general takes MEM", 32'(in_take), 32'b110);
    cyc(3'b111, {6'd1, 6'd2, 6'd3}, '0);
    chk("R9 pool full claim", 32'(unit_claim), 0);
    chk("R9 pool full take", 32'(in_take), 0);
    chk("R6 MEM bound unit4", {unit_dest[9:8], unit_tag[29:24]}, {2'd2, 6'd12});
    cyc(3'b101, {6'd20, 6'd0, 6'd21}, 5'b00001);
    chk("R8 same-cycle reuse", 32'(unit_claim), 32'b00001);
    chk("R4 general gets nothing", 32'(in_take), 32'b001);
    cyc(3'b100, {6'd30, 6'd0, 6'd0}, 5'b01000);
    chk("R4 general claims MEM", 32'(unit_claim), 32'b01000);
    cyc(3'b000, '0, 5'b00010);
    chk("R9 idle no claim", 32'(unit_claim), 0);
    chk("R6 MEM tag unit3", {unit_dest[7:6], unit_tag[23:18]}, {2'd2, 6'd30});
    cyc(3'b000, '0, 5'b00010);
    cyc(3'b000, '0, '0);
    chk("R8 free release ignored", 32'(unit_busy), 32'b11101);

    for (int n = 0; n < 2000; n++) begin
      logic [NU-1:0] r;
      r = NU'($urandom) & NU'($urandom);
      cyc(3'($urandom), (3*TW)'($urandom), r);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule